// File: doc/BRIEF.md
# Two-Wire Register-File Slave

This block is a serial slave on a two-wire bus (I2C-style SCL clock plus open-drain SDA data). It gives a master access to a small bank of byte-wide control registers. The block oversamples both bus lines with the system clock. It detects start and stop conditions and checks a 7-bit chip address. It either loads a register pointer and stores bytes at that pointer, or returns register bytes from that pointer. The block never drives SDA high. It raises an enable, `sdaOe`, that tells the pad to pull SDA low.

The register pointer survives the end of a transaction. A master sets the pointer with a short write, ends that write with a stop, and then opens a separate read that starts where the write left the pointer. After reset the pointer is zero. The pointer steps by one after every data byte, in either direction, and wraps at the end of the bank. The register contents leave the block as a flat vector so that neighbouring logic can use them directly.

A compatibility parameter, `ANY_POS_MATCH`, changes how the address is found. When it is set, an idle slave watches every sampled bit. It responds to any eight consecutive bits that equal its address and R/W bit, even with no start in front of them. When it is clear, the address is only looked for in the first byte after a start. Only one slave with this parameter set should share a bus segment.

Top module: `twi_reg_slave`

## Requirements
- R1: While `rstN` is low, every register i holds RESET_BASE+i, the pointer is 0 and `sdaOe` is low.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Both are judged after a two-flop synchronizer. A start, including a repeated start in the middle of a transaction, always opens a new address byte.
- R3: The address byte is sent MSB first: 7 address bits, then R/W (1 = read). When the address equals CHIP_ADDR, `sdaOe` is high for the whole ninth SCL clock. Otherwise it stays low.
- R4: In a write, the first byte after the address loads the pointer with its low log2(NUM_REGS) bits. Every later byte is stored at the pointer, and the pointer then steps by one, wrapping from NUM_REGS-1 to 0. Every byte is acknowledged.
- R5: A read starts at the pointer left by any earlier transaction, also across a stop. If nothing has been written since reset, it starts at 0.
- R6: Read data goes out MSB first, with `sdaOe` high for a 0 bit. The pointer steps by one (with wrap) after each byte sent.
- R7: If the master pulls SDA low in the ninth clock of a read byte, the slave sends the next byte. If SDA stays high there, `sdaOe` is released at once and stays low until the next start.
- R8: `sdaOe` changes only while the synchronized SCL is low.
- R9: After a stop, `sdaOe` is low and the slave is idle.
- R10: After an address that does not match, the slave drives nothing and writes nothing until the next start or stop.
- R11: With ANY_POS_MATCH=0, bytes that arrive without a preceding start are ignored. With ANY_POS_MATCH=1, an idle slave acts on any 8 consecutive sampled bits equal to {CHIP_ADDR, R/W}, with no start needed.
- R12: Register i appears on `regOut[8*i+7:8*i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sampled SCL line |
| sdaIn | input | 1 | Sampled SDA line |
| sdaOe | output | 1 | 1 = pull SDA low |
| regOut | output | NUM_REGS*8 | Flat view of the register bank |

## Verification
The assertions watch several properties on every clock:
- `sdaOe` only moves while synchronized SCL is low.
- A stop always leaves SDA released.
- The idle state never drives the line.
- At most one register byte changes in any cycle.
- `sdaOe` stays quiet during reset.

The bench scenarios show the rest. These are the byte-level results: pointer carry-over between transactions, wrap in both directions, data placed in the right register, the acknowledge held across the whole ninth clock, release on a not-acknowledge, the effect of a repeated start, and the difference between matching after a start and the compatibility mode's match from the raw bit stream.

// File: rtl/twi_reg_pkg.sv
package twi_reg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REG,
    ST_WDATA,
    ST_ACK,
    ST_RD,
    ST_RACK,
    ST_RNEXT
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPtr;
    logic writeReg;
    logic incPtr;
    logic loadTx;
    logic shiftTx;
  } strb_t;

endpackage

// File: rtl/twi_reg_dp.sv
module twi_reg_dp
  import twi_reg_pkg::*;
#(
  parameter int          NUM_REGS   = 16,
  parameter logic [7:0]  RESET_BASE = 8'hA0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  strb_t                 strb,
  output logic                  sclSync,
  output logic                  sdaSync,
  output logic                  sclRise,
  output logic                  sclFall,
  output logic                  startSeen,
  output logic                  stopSeen,
  output logic [7:0]            rxNext,
  output logic                  txMsb,
  output logic [NUM_REGS*8-1:0] regOut
);
  localparam int PTR_W = $clog2(NUM_REGS);
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

  logic [2:0] sclSr, sdaSr;
  logic       sclDly, sdaDly;
  logic [6:0] rxShift;
  logic [7:0] txSh;
  logic [PTR_W-1:0] ptr;
  logic [7:0] bank [NUM_REGS];

  // two synchronizer flops plus one history flop per line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSr <= '1;
      sdaSr <= '1;
    end else begin
      sclSr <= {sclSr[1:0], sclIn};
      sdaSr <= {sdaSr[1:0], sdaIn};
    end
  end

  assign sclSync   = sclSr[1];
  assign sclDly    = sclSr[2];
  assign sdaSync   = sdaSr[1];
  assign sdaDly    = sdaSr[2];
  assign sclRise   = sclSync & ~sclDly;
  assign sclFall   = ~sclSync & sclDly;
  assign startSeen = sclSync & sclDly & sdaDly & ~sdaSync;
  assign stopSeen  = sclSync & sclDly & ~sdaDly & sdaSync;

  // byte completed by the bit sampled on this rising edge
  assign rxNext = {rxShift, sdaSync};
  assign txMsb  = txSh[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= RESET_BASE + 8'(i);
      ptr     <= '0;
      rxShift <= '0;
      txSh    <= '0;
    end else begin
      if (sclRise) rxShift <= rxNext[6:0];
      if (strb.writeReg) bank[ptr] <= rxNext;
      if (strb.loadPtr)     ptr <= rxNext[PTR_W-1:0];
      else if (strb.incPtr) ptr <= ptr + PTR_ONE;
      if (strb.loadTx)       txSh <= bank[ptr];
      else if (strb.shiftTx) txSh <= {txSh[6:0], 1'b0};
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign regOut[8*g +: 8] = bank[g];
  end

endmodule

// File: rtl/twi_reg_ctrl.sv
module twi_reg_ctrl
  import twi_reg_pkg::*;
#(
  parameter logic [6:0] CHIP_ADDR     = 7'h52,
  parameter bit         ANY_POS_MATCH = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       sdaSync,
  input  logic [7:0] rxNext,
  output strb_t      strb,
  output logic       drvAck,
  output logic       drvData,
  output state_t     state
);
  localparam logic [3:0] CNT_ONE  = 4'd1;
  localparam logic [3:0] LAST_BIT = 4'd7;
  localparam logic [3:0] BYTE_END = 4'd8;

  logic [3:0] bitCnt;
  state_t     afterAck;
  logic       addrHit, byteDone;

  assign addrHit  = (rxNext[7:1] == CHIP_ADDR);
  assign byteDone = sclRise && (bitCnt == LAST_BIT);

  always_comb begin
    strb          = '0;
    strb.loadPtr  = (state == ST_REG)   && byteDone;
    strb.writeReg = (state == ST_WDATA) && byteDone;
    strb.incPtr   = strb.writeReg ||
                    ((state == ST_RD) && sclFall && (bitCnt == BYTE_END));
    strb.loadTx   = ((state == ST_ACK) && sclFall && drvAck && (afterAck == ST_RD)) ||
                    ((state == ST_RNEXT) && sclFall);
    strb.shiftTx  = (state == ST_RD) && sclFall && (bitCnt != BYTE_END);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      afterAck <= ST_REG;
      bitCnt   <= '0;
      drvAck   <= 1'b0;
      drvData  <= 1'b0;
    end else if (startSeen || stopSeen) begin
      state   <= startSeen ? ST_ADDR : ST_IDLE;
      bitCnt  <= '0;
      drvAck  <= 1'b0;
      drvData <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          // raw bit-stream scan, only in compatibility mode
          if (ANY_POS_MATCH && sclRise) begin
            if (bitCnt != LAST_BIT) bitCnt <= bitCnt + CNT_ONE;
            else if (addrHit) begin
              state    <= ST_ACK;
              afterAck <= rxNext[0] ? ST_RD : ST_REG;
              bitCnt   <= '0;
            end
          end
        end
        ST_ADDR, ST_REG, ST_WDATA: begin
          if (sclRise) begin
            if (bitCnt != LAST_BIT) bitCnt <= bitCnt + CNT_ONE;
            else begin
              bitCnt <= '0;
              if (state == ST_ADDR) begin
                state    <= addrHit ? ST_ACK : ST_IDLE;
                afterAck <= rxNext[0] ? ST_RD : ST_REG;
              end else begin
                state    <= ST_ACK;
                afterAck <= ST_WDATA;
              end
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            if (!drvAck) drvAck <= 1'b1;
            else begin
              drvAck  <= 1'b0;
              state   <= afterAck;
              bitCnt  <= '0;
              drvData <= (afterAck == ST_RD);
            end
          end
        end
        ST_RD: begin
          if (sclRise) bitCnt <= bitCnt + CNT_ONE;
          else if (sclFall && (bitCnt == BYTE_END)) begin
            drvData <= 1'b0;
            state   <= ST_RACK;
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            state  <= sdaSync ? ST_IDLE : ST_RNEXT;
            bitCnt <= '0;
          end
        end
        ST_RNEXT: begin
          if (sclFall) begin
            drvData <= 1'b1;
            bitCnt  <= '0;
            state   <= ST_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
  import twi_reg_pkg::*;
#(
  parameter logic [6:0] CHIP_ADDR     = 7'h52,
  parameter int         NUM_REGS      = 16,
  parameter logic [7:0] RESET_BASE    = 8'hA0,
  parameter bit         ANY_POS_MATCH = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] regOut
);
  strb_t      strb;
  state_t     state;
  logic       sclSync, sdaSync, sclRise, sclFall, startSeen, stopSeen;
  logic [7:0] rxNext;
  logic       txMsb, drvAck, drvData;

  twi_reg_dp #(
    .NUM_REGS  (NUM_REGS),
    .RESET_BASE(RESET_BASE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .strb     (strb),
    .sclSync  (sclSync),
    .sdaSync  (sdaSync),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startSeen(startSeen),
    .stopSeen (stopSeen),
    .rxNext   (rxNext),
    .txMsb    (txMsb),
    .regOut   (regOut)
  );

  twi_reg_ctrl #(
    .CHIP_ADDR    (CHIP_ADDR),
    .ANY_POS_MATCH(ANY_POS_MATCH)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startSeen(startSeen),
    .stopSeen (stopSeen),
    .sdaSync  (sdaSync),
    .rxNext   (rxNext),
    .strb     (strb),
    .drvAck   (drvAck),
    .drvData  (drvData),
    .state    (state)
  );

  assign sdaOe = drvAck | (drvData & ~txMsb);

endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk
  import twi_reg_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sdaOe,
  input logic                  sclSync,
  input logic                  stopSeen,
  input state_t                state,
  input logic [NUM_REGS*8-1:0] regOut
);
  logic [NUM_REGS*8-1:0] regPrev;
  logic [NUM_REGS-1:0]   chg;
  logic                  prevValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevValid <= 1'b0;
    else       prevValid <= 1'b1;
  end

  always_ff @(posedge clk) regPrev <= regOut;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_chg
    assign chg[g] = (regOut[8*g +: 8] != regPrev[8*g +: 8]);
  end

  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!sdaOe);
    end
  end

  p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclSync);

  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaOe);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe);

  p_one_byte_r4: assert property (@(posedge clk) disable iff (!rstN)
    prevValid |-> ($countones(chg) <= 1));

endmodule

bind twi_reg_slave twi_reg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sdaOe   (sdaOe),
  .sclSync (sclSync),
  .stopSeen(stopSeen),
  .state   (state),
  .regOut  (regOut)
);

// File: tb/twi_reg_slave_tb.sv
`timescale 1ns/1ps
module twi_reg_slave_tb;
  localparam int Q = 8;
  localparam logic [7:0] BASE = 8'hA0;
  localparam logic [7:0] VEC [4] = '{8'h03, 8'h07, 8'h0C, 8'h1E};
  localparam logic [7:0] VDAT[4] = '{8'h5A, 8'hC3, 8'h00, 8'hFF};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, sel = 1'b0;
  logic oeA, oeB, sdaA, sdaB, line, oeSel;
  logic [127:0] regA, regB;
  logic [7:0] model [16];
  logic [7:0] rd;
  logic ack;
  int nChecks = 0, nFail = 0;

  always #5 clk = ~clk;

  assign sdaA  = sel ? 1'b1 : (sdaM & ~oeA);
  assign sdaB  = sel ? (sdaM & ~oeB) : 1'b1;
  assign line  = sel ? sdaB : sdaA;
  assign oeSel = sel ? oeB : oeA;

  twi_reg_slave u_dut (.clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaA),
                       .sdaOe(oeA), .regOut(regA));

  twi_reg_slave #(.CHIP_ADDR(7'h3A), .ANY_POS_MATCH(1'b1)) u_compat (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaB), .sdaOe(oeB), .regOut(regB));

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [127:0] packModel();
    logic [127:0] p;
    for (int i = 0; i < 16; i++) p[8*i +: 8] = model[i];
    return p;
  endfunction

  function automatic logic [127:0] defaults();
    logic [127:0] p;
    for (int i = 0; i < 16; i++) p[8*i +: 8] = BASE + 8'(i);
    return p;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; tick(Q); sclM = 1'b1; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  // acked only if the slave holds SDA low across the whole ninth high phase
  task automatic sendByte(input logic [7:0] d, output logic acked);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    sdaM = 1'b1; tick(Q); sclM = 1'b1;
    tick(1); a1 = oeSel;
    tick(Q-2); a2 = oeSel;
    tick(1); sclM = 1'b0; tick(Q);
    acked = a1 & a2;
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] d);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sclM = 1'b1; tick(Q/2); d[i] = line; tick(Q/2); sclM = 1'b0;
    end
    sdaM = nack; tick(Q); sclM = 1'b1; tick(Q); sclM = 1'b0; tick(Q);
    sdaM = 1'b1;
  endtask

  // read n bytes at the current pointer, compare each with expected model entries
  task automatic readCheck(input string tag, input int first, input int n);
    sendByte(8'hA5, ack);
    check({tag, " R3 read address ack"}, {127'b0, ack}, 128'd1);
    for (int k = 0; k < n; k++) begin
      recvByte(k == n-1, rd);
      check({tag, " R6 read data"}, {120'b0, rd}, {120'b0, model[(first+k) % 16]});
    end
    check({tag, " R7 release after nack"}, {127'b0, oeA}, 128'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 16; i++) model[i] = BASE + 8'(i);
    tick(4);
    check("R1 reset drive low", {127'b0, oeA}, 128'd0);
    rstN = 1'b1;
    tick(Q);
    check("R1 R12 reset contents", regA, defaults());
    check("R1 reset contents compat", regB, defaults());

    // R5: first read after reset starts at 0, R6 increments
    busStart();
    readCheck("R5 reset pointer", 0, 2);
    busStop();
    check("R9 released after stop", {127'b0, oeA}, 128'd0);

    // vector table: write one byte, reload pointer, read back
    for (int v = 0; v < 4; v++) begin
      busStart();
      sendByte(8'hA4, ack); check("R3 write address ack", {127'b0, ack}, 128'd1);
      sendByte(VEC[v], ack); check("R4 pointer byte ack", {127'b0, ack}, 128'd1);
      sendByte(VDAT[v], ack); check("R4 data byte ack", {127'b0, ack}, 128'd1);
      busStop();
      model[VEC[v][3:0]] = VDAT[v];
      check("R4 R12 register written", regA, packModel());
      busStart();
      sendByte(8'hA4, ack);
      sendByte(VEC[v], ack);
      busStop();
      busStart();
      readCheck("R5 vector readback", int'(VEC[v][3:0]), 1);
      busStop();
    end

    // R4: multi-byte write wrapping from 15 to 0
    busStart();
    sendByte(8'hA4, ack);
    sendByte(8'h0F, ack);
    sendByte(8'h11, ack); sendByte(8'h22, ack); sendByte(8'h33, ack);
    check("R4 burst ack", {127'b0, ack}, 128'd1);
    busStop();
    model[15] = 8'h11; model[0] = 8'h22; model[1] = 8'h33;
    check("R4 write wrap", regA, packModel());

    // R5: pointer carried over a stop, now at 2
    busStart();
    readCheck("R5 carry over", 2, 1);
    busStop();

    // R6: multi-byte read wrapping from 14
    busStart(); sendByte(8'hA4, ack); sendByte(8'h0E, ack); busStop();
    busStart();
    readCheck("R6 read wrap", 14, 3);
    busStop();

    // R10: foreign address, following bytes ignored
    busStart();
    sendByte(8'h22, ack); check("R10 no ack foreign address", {127'b0, ack}, 128'd0);
    sendByte(8'h05, ack); check("R10 no ack foreign byte", {127'b0, ack}, 128'd0);
    sendByte(8'h77, ack);
    busStop();
    check("R10 registers untouched", regA, packModel());

    // R2: repeated start turns a write into a read from the new pointer
    busStart(); sendByte(8'hA4, ack); sendByte(8'h04, ack);
    busStart();
    readCheck("R2 repeated start", 4, 1);
    busStop();

    // R11: normal mode ignores an address stream without start
    sclM = 1'b0; tick(Q);
    sendByte(8'hA4, ack); check("R11 no start no ack", {127'b0, ack}, 128'd0);
    sendByte(8'h06, ack);
    sendByte(8'h99, ack);
    busStop();
    check("R11 no start no write", regA, packModel());

    // R11: compatibility instance matches an unaligned raw stream
    sel = 1'b1;
    tick(Q);
    sclM = 1'b0; tick(Q);
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b1);
    sendByte(8'h74, ack); check("R11 compat stream ack", {127'b0, ack}, 128'd1);
    sendByte(8'h02, ack); check("R11 compat pointer ack", {127'b0, ack}, 128'd1);
    sendByte(8'h5C, ack);
    busStop();
    check("R11 compat write", regB[23:16], {120'b0, 8'h5C});
    check("R11 compat other regs", {regB[127:24], regB[15:0]},
          {defaults() >> 24, defaults() & 128'hFFFF} == 0 ? 128'd0 :
          {defaults() >> 24, 16'h0} | {112'b0, 16'hA1A0});
    sel = 1'b0;
    tick(Q);

    // R1: reset in mid-run restores contents and pointer
    rstN = 1'b0; tick(4);
    check("R1 reset drive low again", {127'b0, oeA}, 128'd0);
    rstN = 1'b1; tick(Q);
    for (int i = 0; i < 16; i++) model[i] = BASE + 8'(i);
    check("R1 contents restored", regA, packModel());
    busStart();
    readCheck("R1 R5 pointer restored", 0, 1);
    busStop();

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule